// File: doc/BRIEF.md
# Shift-Add YUV to RGB Colour Converter

This block turns a stream of full-resolution luma/chroma pixels into 8-bit red, green and blue. Each cycle it can accept one pixel made of an unsigned luma byte and two chroma bytes. The chroma bytes are stored with a +128 bias. A valid/ready handshake carries pixels in at the input and out at the output. The block keeps them in order, and one RGB pixel leaves for every pixel that enters.

The conversion matrix uses fixed coefficients that are exact multiples of 1/64. Every product is a small sum of shifted copies of the chroma value, so the block has no multipliers. Red adds 11/8 of the red-difference chroma to luma. Blue adds 111/64 of the blue-difference chroma. Green subtracts 11/32 of the blue-difference chroma and 45/64 of the red-difference chroma. The result is rounded to the nearest integer and clamped to the byte range.

The work is split across three register stages: bias removal and partial products, then summation, then rounding and clamping. A valid bit travels beside each stage. When the consumer holds off, one shared enable freezes the whole pipeline.

Top module: `yuv_rgb_conv`

## Requirements
- R1: Chroma bytes are made signed by inverting bit 7. A chroma byte of 0x80 therefore counts as zero, and with both chroma bytes at 0x80 the outputs R, G and B all equal the luma byte.
- R2: Red output = round(Y + 88·V/64), where V is the signed red-difference chroma (inV with bit 7 inverted) and Y is the unsigned luma byte.
- R3: Green output = round(Y − 22·U/64 − 45·V/64), where U is the signed blue-difference chroma (inU with bit 7 inverted).
- R4: Blue output = round(Y + 111·U/64).
- R5: Rounding adds 32/64 before the fraction is dropped toward minus infinity, so an exact half rounds up. Example: Y=100, U=0x80, V=0x84 gives R=106, G=97, B=100.
- R6: A channel result below 0 is output as 0. Example: Y=0, U=V=0x00 gives R=0, G=134, B=0.
- R7: A channel result above 255 is output as 255. Example: Y=255, U=V=0xFF gives R=255, G=122, B=255.
- R8: While outReady stays high, a pixel accepted at one clock edge shows up on the outputs with outValid high after the third edge that follows.
- R9: inReady is high whenever outValid is low. While outValid is high, inReady equals outReady.
- R10: While outValid is high and outReady is low, the next cycle keeps outValid high with R, G and B unchanged. Pixels leave in arrival order, with none lost and none duplicated.
- R11: A synchronous active-high rst clears every stage valid bit, so outValid is low on the cycle after rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Block can take a pixel |
| inY | input | 8 | Luma, unsigned |
| inU | input | 8 | Blue-difference chroma, +128 biased |
| inV | input | 8 | Red-difference chroma, +128 biased |
| outValid | output | 1 | Output pixel present |
| outReady | input | 1 | Consumer takes the output pixel |
| outR | output | 8 | Red |
| outG | output | 8 | Green |
| outB | output | 8 | Blue |

## Verification
Two events can fall in the same cycle: a new pixel entering while the output is stalled, and the stall being released. The bench provokes this by toggling outReady in fixed patterns while input bubbles are inserted and pixels wait at the input. At every cycle where outReady drops with a pixel waiting, it checks that outValid and the RGB outputs are held. It then checks that the sequence of emitted pixels matches the reference model one-for-one, with nothing lost and nothing repeated. The clamp limits are driven with chroma pinned at 0x00 and 0xFF.

// File: rtl/yuv_rgb_pkg.sv
package yuv_rgb_pkg;
  localparam int PIX_W   = 8;
  localparam int FRAC_W  = 6;
  localparam int SUM_W   = PIX_W + FRAC_W + 3;
  localparam int STAGES  = 3;

  localparam logic [PIX_W-1:0] COEF_R_V = 8'd88;
  localparam logic [PIX_W-1:0] COEF_G_U = 8'd22;
  localparam logic [PIX_W-1:0] COEF_G_V = 8'd45;
  localparam logic [PIX_W-1:0] COEF_B_U = 8'd111;

  typedef struct packed {
    logic s1En;
    logic s2En;
    logic s3En;
  } stageStrobe_t;
endpackage

// File: rtl/yuv_rgb_term.sv
module yuv_rgb_term #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 17,
  parameter logic [IN_W-1:0] COEF = '0
) (
  input  logic signed [IN_W-1:0]  chroma,
  output logic signed [OUT_W-1:0] product
);
  logic signed [OUT_W-1:0] extended;
  logic signed [OUT_W-1:0] partial [IN_W];

  assign extended = {{(OUT_W-IN_W){chroma[IN_W-1]}}, chroma};

  genvar b;
  generate
    for (b = 0; b < IN_W; b++) begin : g_bit
      if (COEF[b]) begin : g_on
        assign partial[b] = extended <<< b;
      end else begin : g_off
        assign partial[b] = '0;
      end
    end
  endgenerate

  always_comb begin
    product = '0;
    for (int k = 0; k < IN_W; k++) begin
      product = product + partial[k];
    end
  end
endmodule

// File: rtl/yuv_rgb_ctrl.sv
module yuv_rgb_ctrl
  import yuv_rgb_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output logic         inReady,
  output logic         outValid,
  input  logic         outReady,
  output stageStrobe_t strobe
);
  logic [STAGES-1:0] stageValid;
  logic              advance;

  assign advance  = outReady | ~stageValid[STAGES-1];
  assign inReady  = advance;
  assign outValid = stageValid[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid[0] <= 1'b0;
    end else if (advance) begin
      stageValid[0] <= inValid;
    end
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stageValid[s] <= 1'b0;
        end else if (advance) begin
          stageValid[s] <= stageValid[s-1];
        end
      end
    end
  endgenerate

  assign strobe.s1En = advance & inValid;
  assign strobe.s2En = advance & stageValid[0];
  assign strobe.s3En = advance & stageValid[1];
endmodule

// File: rtl/yuv_rgb_dp.sv
module yuv_rgb_dp
  import yuv_rgb_pkg::*;
(
  input  logic             clk,
  input  stageStrobe_t     strobe,
  input  logic [PIX_W-1:0] lumaIn,
  input  logic [PIX_W-1:0] cbIn,
  input  logic [PIX_W-1:0] crIn,
  output logic [PIX_W-1:0] redOut,
  output logic [PIX_W-1:0] greenOut,
  output logic [PIX_W-1:0] blueOut
);
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam logic signed [SUM_W-1:0] HALF_LSB = SUM_W'(1) <<< (FRAC_W - 1);

  logic signed [PIX_W-1:0] cbSigned, crSigned;
  logic signed [SUM_W-1:0] rvTerm, guTerm, gvTerm, buTerm;

  assign cbSigned = {~cbIn[PIX_W-1], cbIn[PIX_W-2:0]};
  assign crSigned = {~crIn[PIX_W-1], crIn[PIX_W-2:0]};

  yuv_rgb_term #(.IN_W(PIX_W), .OUT_W(SUM_W), .COEF(COEF_R_V))
    rvTerm_i (.chroma(crSigned), .product(rvTerm));
  yuv_rgb_term #(.IN_W(PIX_W), .OUT_W(SUM_W), .COEF(COEF_G_U))
    guTerm_i (.chroma(cbSigned), .product(guTerm));
  yuv_rgb_term #(.IN_W(PIX_W), .OUT_W(SUM_W), .COEF(COEF_G_V))
    gvTerm_i (.chroma(crSigned), .product(gvTerm));
  yuv_rgb_term #(.IN_W(PIX_W), .OUT_W(SUM_W), .COEF(COEF_B_U))
    buTerm_i (.chroma(cbSigned), .product(buTerm));

  // stage 1: scaled luma and partial products
  logic signed [SUM_W-1:0] lumaQ, rvQ, guQ, gvQ, buQ;
  always_ff @(posedge clk) begin
    if (strobe.s1En) begin
      lumaQ <= $signed({{(SUM_W-PIX_W-FRAC_W){1'b0}}, lumaIn, {FRAC_W{1'b0}}});
      rvQ   <= rvTerm;
      guQ   <= guTerm;
      gvQ   <= gvTerm;
      buQ   <= buTerm;
    end
  end

  // stage 2: channel sums
  logic signed [SUM_W-1:0] redSum, greenSum, blueSum;
  always_ff @(posedge clk) begin
    if (strobe.s2En) begin
      redSum   <= lumaQ + rvQ;
      greenSum <= lumaQ - guQ - gvQ;
      blueSum  <= lumaQ + buQ;
    end
  end

  function automatic logic [PIX_W-1:0] roundClamp(input logic signed [SUM_W-1:0] sum);
    logic signed [SUM_W-1:0] biased;
    logic signed [SUM_W-1:0] whole;
    biased = sum + HALF_LSB;
    whole  = biased >>> FRAC_W;
    if (whole < 0)
      return '0;
    else if (whole > PIX_MAX)
      return PIX_W'(PIX_MAX);
    else
      return whole[PIX_W-1:0];
  endfunction

  // stage 3: round and clamp
  always_ff @(posedge clk) begin
    if (strobe.s3En) begin
      redOut   <= roundClamp(redSum);
      greenOut <= roundClamp(greenSum);
      blueOut  <= roundClamp(blueSum);
    end
  end
endmodule

// File: rtl/yuv_rgb_conv.sv
module yuv_rgb_conv
  import yuv_rgb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output logic       inReady,
  input  logic [7:0] inY,
  input  logic [7:0] inU,
  input  logic [7:0] inV,
  output logic       outValid,
  input  logic       outReady,
  output logic [7:0] outR,
  output logic [7:0] outG,
  output logic [7:0] outB
);
  stageStrobe_t strobe;

  yuv_rgb_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .strobe(strobe)
  );

  yuv_rgb_dp dp_i (
    .clk(clk), .strobe(strobe), .lumaIn(inY), .cbIn(inU), .crIn(inV),
    .redOut(outR), .greenOut(outG), .blueOut(outB)
  );
endmodule

// File: rtl/yuv_rgb_conv_chk.sv
module yuv_rgb_conv_chk (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic       inReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outR,
  input logic [7:0] outG,
  input logic [7:0] outB
);
  // R8
  latency_three_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) ##1 outReady ##1 outReady |=> outValid);

  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> inReady);

  // R9
  full_ready_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (inReady == outReady));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outR) && $stable(outG) && $stable(outB)));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !outValid);
endmodule

bind yuv_rgb_conv yuv_rgb_conv_chk chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady),
  .outR(outR), .outG(outG), .outB(outB)
);

// File: tb/yuv_rgb_conv_tb_top.sv
module yuv_rgb_conv_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] inY = '0, inU = '0, inV = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [7:0] outR, outG, outB;

  int errors = 0;
  int checks = 0;
  logic [7:0] srcY [64];
  logic [7:0] srcU [64];
  logic [7:0] srcV [64];

  always #10 clk = ~clk;

  yuv_rgb_conv dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inY(inY), .inU(inU), .inV(inV), .outValid(outValid), .outReady(outReady),
    .outR(outR), .outG(outG), .outB(outB)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clampCh(input int s);
    int q;
    q = (s + 32) >>> 6;
    if (q < 0) return 0;
    if (q > 255) return 255;
    return q;
  endfunction

  function automatic int refPix(input logic [7:0] y, input logic [7:0] u, input logic [7:0] v);
    int su, sv, yy;
    su = int'(u) - 128;
    sv = int'(v) - 128;
    yy = int'(y) * 64;
    return (clampCh(yy + 88 * sv) << 16) | (clampCh(yy - 22 * su - 45 * sv) << 8)
           | clampCh(yy + 111 * su);
  endfunction

  function automatic int outPix();
    return {8'h00, outR, outG, outB};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; outReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runStream(input string tag, input int n, input int readyMode, input int gapMode);
    int sIdx = 0;
    int oIdx = 0;
    int cyc = 0;
    logic pv = 1'b0;
    logic pr = 1'b1;
    int pOut = 0;
    while (oIdx < n && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      case (readyMode)
        0: outReady = 1'b1;
        1: outReady = (cyc % 3) != 0;
        default: outReady = (cyc >= 5 && cyc < 15) ? 1'b0 : ((cyc % 2) == 0);
      endcase
      if (sIdx < n && !(gapMode != 0 && (cyc % 4) == 1)) begin
        inValid = 1'b1; inY = srcY[sIdx]; inU = srcU[sIdx]; inV = srcV[sIdx];
      end else begin
        inValid = 1'b0;
      end
      #1;
      if (pv && !pr) begin
        chk("R10 stall keeps valid", int'(outValid), 1);
        chk("R10 stall keeps data", outPix(), pOut);
      end
      if (!outValid) chk("R9 ready when empty", int'(inReady), 1);
      else chk("R9 ready follows output", int'(inReady), int'(outReady));
      if (outValid && outReady) begin
        chk(tag, outPix(), refPix(srcY[oIdx], srcU[oIdx], srcV[oIdx]));
        oIdx++;
      end
      if (inValid && inReady) sIdx++;
      pv = outValid; pr = outReady; pOut = outPix();
    end
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #1;
      chk("R10 no duplicate output", int'(outValid), 0);
      @(negedge clk);
    end
    chk("R10 all pixels delivered", oIdx, n);
  endtask

  task automatic testReset();
    doReset();
    #1;
    chk("R11 valid low after reset", int'(outValid), 0);
    chk("R9 ready after reset", int'(inReady), 1);
  endtask

  task automatic testNeutral();
    for (int i = 0; i < 8; i++) begin
      srcY[i] = 8'(i * 36); srcU[i] = 8'h80; srcV[i] = 8'h80;
    end
    runStream("R1 neutral chroma", 8, 0, 0);
    srcY[0] = 8'd77; srcU[0] = 8'h80; srcV[0] = 8'h80;
    runStream("R1 neutral single", 1, 0, 0);
    chk("R1 grey equals luma", outPix(), {8'h00, 8'd77, 8'd77, 8'd77});
  endtask

  task automatic testRound();
    srcY[0] = 8'd100; srcU[0] = 8'h80; srcV[0] = 8'h84;
    runStream("R5 half rounds up", 1, 0, 0);
    chk("R5 literal value", outPix(), {8'h00, 8'd106, 8'd97, 8'd100});
  endtask

  task automatic testFormulas();
    for (int i = 0; i < 40; i++) begin
      srcY[i] = 8'(i * 37 + 11); srcU[i] = 8'(i * 53 + 90); srcV[i] = 8'(i * 29 + 140);
    end
    runStream("R2 R3 R4 sweep", 40, 0, 0);
  endtask

  task automatic testClamp();
    srcY[0] = 8'd0;   srcU[0] = 8'h00; srcV[0] = 8'h00;
    runStream("R6 low corner", 1, 0, 0);
    chk("R6 clamp to zero", outPix(), {8'h00, 8'd0, 8'd134, 8'd0});
    srcY[0] = 8'd255; srcU[0] = 8'hFF; srcV[0] = 8'hFF;
    runStream("R7 high corner", 1, 0, 0);
    chk("R7 clamp to max", outPix(), {8'h00, 8'd255, 8'd122, 8'd255});
  endtask

  task automatic testLatency();
    int seen = 0;
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b1; inY = 8'd50; inU = 8'h80; inV = 8'h80;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      #1;
      if (outValid && seen == 0) seen = k;
    end
    chk("R8 three-cycle latency", seen, 3);
  endtask

  task automatic testBackpressure();
    for (int i = 0; i < 48; i++) begin
      srcY[i] = 8'(i * 91 + 3); srcU[i] = 8'(i * 17); srcV[i] = 8'(255 - i * 13);
    end
    runStream("R10 order under stall pattern A", 48, 1, 1);
    runStream("R10 order under stall pattern B", 48, 2, 0);
  endtask

  task automatic testMidReset();
    @(negedge clk);
    inValid = 1'b1; outReady = 1'b0; inY = 8'd9; inU = 8'd9; inV = 8'd9;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R10 pipeline filled before reset", int'(outValid), 1);
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk);
    #1;
    chk("R11 reset clears in flight", int'(outValid), 0);
    rst = 1'b0; outReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R11 nothing emerges after reset", int'(outValid), 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testNeutral();
    testRound();
    testFormulas();
    testClamp();
    testLatency();
    testBackpressure();
    testMidReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule